// File: doc/BRIEF.md
# UART Status Flag and Interrupt Controller

This block sits next to the transmit and receive datapaths of a UART. It turns their event strobes into eight status flags and drives three interrupt request lines: transmit, receive and error. The datapaths report the following events:

- a transmit character moving from the holding register into the shifter
- the shifter finishing
- a received character being ready
- every sampled receive bit
- noise, framing and parity detections

The block also holds the enable bits, the receive data register and the transmit holding register. A small register port gives access to all of them.

Software clears a flag in two steps. It first reads the status register while the flag is set, which arms the flag. It then accesses the data register: a read clears the armed receive-side flags, and a write clears the armed transmit-side flags.

Two state machines carry the sequencing:

- **Transmit machine.** It tracks holding-register and shifter occupancy through four states:
  - `TX_EMPTY`: both empty
  - `TX_QUEUED`: holding register full, shifter idle
  - `TX_SHIFT`: shifter busy, holding register empty
  - `TX_BOTH`: both full

  Its transitions are:
  - write: `TX_EMPTY`→`TX_QUEUED` and `TX_SHIFT`→`TX_BOTH`
  - load: `TX_QUEUED`→`TX_SHIFT`
  - shift done: `TX_SHIFT`→`TX_EMPTY`, `TX_BOTH`→`TX_QUEUED`, and `TX_SHIFT`→`TX_QUEUED` when a write lands in the same cycle
- **Idle machine.** It has three states:
  - `IDS_HUNT`: counting consecutive ones
  - `IDS_SEEN`: idle flagged
  - `IDS_LOCK`: flag cleared, waiting for a character

  Its transitions are:
  - threshold reached: `IDS_HUNT`→`IDS_SEEN`
  - idle flag cleared: `IDS_SEEN`→`IDS_LOCK`
  - character received: `IDS_LOCK`→`IDS_HUNT`

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status register reads 0xC0, both control registers read 0x00, and all three interrupt lines are low.
- R2: The transmit-empty flag (status bit 7) sets when `tx_load_stb` arrives while a written character is held. With control A bit 7 set, that flag raises `tx_irq`.
- R3: The transmit-complete flag (status bit 6) sets only while both the holding register and the shifter are empty and `tx_brk_busy` is low. With control A bit 6 set, it raises `tx_irq`.
- R4: `rx_char_stb` loads `rx_char_data` into the receive data register and sets receive-full (status bit 5), provided that flag is clear. With control A bit 5 set, receive-full raises `rx_irq`.
- R5: The idle flag (status bit 4) sets on the 10th consecutive one (8-bit mode, `rx_nine_bit` low) or the 11th (9-bit mode). A received zero restarts the count. With control A bit 4 set, the idle flag raises `rx_irq`.
- R6: Once the idle flag has been cleared, it does not set again until a character has been received.
- R7: A character that arrives while receive-full is still set sets overrun (status bit 3). The data register keeps the old character.
- R8: `rx_noise_stb`, `rx_frame_stb` and `rx_parity_stb` set status bits 2, 1 and 0 respectively.
- R9: `err_irq` is high when any of status bits 3..0 is set together with the matching control B bit 3..0.
- R10: A data-register read clears only the receive-side flags (bits 5..0) that were set at the last status read. A data-register write clears only the transmit-side flags (bits 7..6) that were set at that read. A data access without a prior arming read clears nothing.
- R11: The register select picks one of four registers:
  - 0: status, read-only
  - 1: control A, bits 7..4 writable, bits 3..0 read as zero
  - 2: control B, bits 3..0 writable, bits 7..4 read as zero
  - 3: data. A read returns the receive data register. A write loads `tx_data` and raises `tx_full`.
- R12: When a setting event and a clear of the same flag land in the same cycle, the flag stays set. A character that arrives during a clearing data read is stored without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| tx_load_stb | input | 1 | Holding register moved to shifter |
| tx_shift_done_stb | input | 1 | Shifter finished a character |
| tx_brk_busy | input | 1 | Break or idle character being generated |
| tx_data | output | 8 | Transmit holding register |
| tx_full | output | 1 | Holding register occupied |
| rx_char_stb | input | 1 | Received character ready |
| rx_char_data | input | 8 | Received character |
| rx_bit_stb | input | 1 | Receive bit sampled |
| rx_bit_val | input | 1 | Value of the sampled bit |
| rx_nine_bit | input | 1 | 9-bit data mode |
| rx_noise_stb | input | 1 | Noise detected in frame |
| rx_frame_stb | input | 1 | Stop bit sampled as zero |
| rx_parity_stb | input | 1 | Parity mismatch |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The hardest situation to reach is the re-arming rule of the idle machine: after the idle flag is cleared, a long run of ones must be ignored until a character arrives. The bench reaches it in steps:

1. Build one run of ones that a zero interrupts, to show that the count restarts.
2. Complete a run to the 8-bit threshold, then clear the flag with a status read followed by a data read.
3. Send 25 further ones, which must not set the flag.
4. Send one character, switch to 9-bit mode, and confirm that the flag sets on the 11th one and not on the 10th.

A second hard case is a character arriving in the very cycle of a clearing data read. The bench drives both in one cycle.

// File: rtl/uflg_pkg.sv
package uflg_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_STAT = 2'd0,
        ADDR_CTLA = 2'd1,
        ADDR_CTLB = 2'd2,
        ADDR_DATA = 2'd3
    } uflg_addr_e;

    // Field order equals status bit order, 7 down to 0.
    typedef struct packed {
        logic txe;
        logic txc;
        logic rxf;
        logic idl;
        logic ovr;
        logic nse;
        logic frm;
        logic par;
    } uflg_status_t;

    typedef enum logic [1:0] {
        TX_EMPTY  = 2'd0,
        TX_QUEUED = 2'd1,
        TX_SHIFT  = 2'd2,
        TX_BOTH   = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        IDS_HUNT = 2'd0,
        IDS_SEEN = 2'd1,
        IDS_LOCK = 2'd2
    } idle_state_e;

endpackage

// File: rtl/uflg_tx_fsm.sv
module uflg_tx_fsm
    import uflg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             load_stb,
    input  logic             shift_done_stb,
    input  logic             brk_busy,
    input  logic             clr_txe,
    input  logic             clr_txc,
    output logic             txe,
    output logic             txc,
    output logic [REG_W-1:0] tx_data,
    output logic             tx_full
);

    tx_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_EMPTY:  if (data_wr) st_d = TX_QUEUED;
            TX_QUEUED: if (load_stb) st_d = TX_SHIFT;
            TX_SHIFT: begin
                if (shift_done_stb && data_wr) st_d = TX_QUEUED;
                else if (data_wr)              st_d = TX_BOTH;
                else if (shift_done_stb)       st_d = TX_EMPTY;
            end
            TX_BOTH:   if (shift_done_stb) st_d = TX_QUEUED;
            default:   st_d = TX_EMPTY;
        endcase
    end

    logic txe_q, txc_q;
    logic [REG_W-1:0] data_q;
    logic set_txe, set_txc;

    assign set_txe = load_stb && (st_q == TX_QUEUED);
    assign set_txc = (st_q == TX_EMPTY) && !brk_busy && !data_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txe_q  <= 1'b1;
            txc_q  <= 1'b1;
            data_q <= '0;
        end else begin
            if (set_txe)      txe_q <= 1'b1;
            else if (clr_txe) txe_q <= 1'b0;
            if (set_txc)      txc_q <= 1'b1;
            else if (clr_txc) txc_q <= 1'b0;
            if (data_wr)      data_q <= wdata;
        end
    end

    assign txe     = txe_q;
    assign txc     = txc_q;
    assign tx_data = data_q;
    assign tx_full = (st_q == TX_QUEUED) || (st_q == TX_BOTH);

    // R2
    txe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txe_q) |-> $past(load_stb && st_q == TX_QUEUED));

    // R3
    txc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc_q) |-> $past(st_q == TX_EMPTY && !brk_busy));

endmodule

// File: rtl/uflg_rx_track.sv
module uflg_rx_track
    import uflg_pkg::*;
#(
    parameter int IDLE_ONES_8 = 10,
    parameter int IDLE_ONES_9 = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_stb,
    input  logic [REG_W-1:0] char_data,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             nine_bit,
    input  logic             noise_stb,
    input  logic             frame_stb,
    input  logic             parity_stb,
    input  logic             clr_rxf,
    input  logic             clr_idl,
    input  logic             clr_ovr,
    input  logic             clr_nse,
    input  logic             clr_frm,
    input  logic             clr_par,
    output logic             rxf,
    output logic             idl,
    output logic             ovr,
    output logic             nse,
    output logic             frm,
    output logic             par,
    output logic [REG_W-1:0] rx_data
);

    localparam int IDLE_MAX = (IDLE_ONES_9 > IDLE_ONES_8) ? IDLE_ONES_9 : IDLE_ONES_8;
    localparam int CNT_W    = $clog2(IDLE_MAX + 1);
    localparam logic [CNT_W-1:0] THR8 = CNT_W'(IDLE_ONES_8);
    localparam logic [CNT_W-1:0] THR9 = CNT_W'(IDLE_ONES_9);

    idle_state_e ids_q, ids_d;
    logic [CNT_W-1:0] ones_q, ones_inc, thr;
    logic hit;

    assign thr      = nine_bit ? THR9 : THR8;
    assign ones_inc = ones_q + CNT_W'(1);
    assign hit      = (ids_q == IDS_HUNT) && bit_stb && bit_val && (ones_inc == thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ids_q <= IDS_HUNT;
        else        ids_q <= ids_d;
    end

    always_comb begin
        ids_d = ids_q;
        unique case (ids_q)
            IDS_HUNT: if (hit)      ids_d = IDS_SEEN;
            IDS_SEEN: if (clr_idl)  ids_d = IDS_LOCK;
            IDS_LOCK: if (char_stb) ids_d = IDS_HUNT;
            default:  ids_d = IDS_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ones_q <= '0;
        else if (ids_q != IDS_HUNT)       ones_q <= '0;
        else if (bit_stb) begin
            if (!bit_val || hit)          ones_q <= '0;
            else                          ones_q <= ones_inc;
        end
    end

    logic rxf_q, idl_q, ovr_q, nse_q, frm_q, par_q;
    logic [REG_W-1:0] data_q;
    logic unread;

    assign unread = rxf_q && !clr_rxf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxf_q  <= 1'b0;
            idl_q  <= 1'b0;
            ovr_q  <= 1'b0;
            nse_q  <= 1'b0;
            frm_q  <= 1'b0;
            par_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (char_stb && unread)       ovr_q <= 1'b1;
            else if (clr_ovr)             ovr_q <= 1'b0;
            if (char_stb && !unread) begin
                rxf_q  <= 1'b1;
                data_q <= char_data;
            end else if (clr_rxf) begin
                rxf_q  <= 1'b0;
            end
            if (hit)             idl_q <= 1'b1;
            else if (clr_idl)    idl_q <= 1'b0;
            if (noise_stb)       nse_q <= 1'b1;
            else if (clr_nse)    nse_q <= 1'b0;
            if (frame_stb)       frm_q <= 1'b1;
            else if (clr_frm)    frm_q <= 1'b0;
            if (parity_stb)      par_q <= 1'b1;
            else if (clr_par)    par_q <= 1'b0;
        end
    end

    assign rxf     = rxf_q;
    assign idl     = idl_q;
    assign ovr     = ovr_q;
    assign nse     = nse_q;
    assign frm     = frm_q;
    assign par     = par_q;
    assign rx_data = data_q;

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_stb && rxf_q && !clr_rxf) |=> (ovr_q && $stable(data_q)));

    // R5
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idl_q) |-> $past(ids_q == IDS_HUNT && bit_stb && bit_val));

    // R6
    idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ids_q == IDS_LOCK) |=> !idl_q);

endmodule

// File: rtl/uflg_regif.sv
module uflg_regif
    import uflg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  uflg_status_t     status_i,
    input  logic [REG_W-1:0] rx_data,
    output logic [REG_W-1:0] reg_rdata,
    output logic [3:0]       ien_trx,
    output logic [3:0]       ien_err,
    output logic             data_wr,
    output logic             data_rd,
    output uflg_status_t     clr_o
);

    uflg_status_t arm_q;
    logic [3:0] ien_trx_q, ien_err_q;
    logic stat_rd;

    assign stat_rd = reg_rd && (reg_sel == ADDR_STAT);
    assign data_rd = reg_rd && (reg_sel == ADDR_DATA);
    assign data_wr = reg_wr && (reg_sel == ADDR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_trx_q <= '0;
            ien_err_q <= '0;
        end else if (reg_wr) begin
            if (reg_sel == ADDR_CTLA) ien_trx_q <= reg_wdata[7:4];
            if (reg_sel == ADDR_CTLB) ien_err_q <= reg_wdata[3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (stat_rd) begin
            arm_q <= status_i;
        end else begin
            if (data_wr) begin
                arm_q.txe <= 1'b0;
                arm_q.txc <= 1'b0;
            end
            if (data_rd) begin
                arm_q.rxf <= 1'b0;
                arm_q.idl <= 1'b0;
                arm_q.ovr <= 1'b0;
                arm_q.nse <= 1'b0;
                arm_q.frm <= 1'b0;
                arm_q.par <= 1'b0;
            end
        end
    end

    always_comb begin
        clr_o = '0;
        if (data_wr) begin
            clr_o.txe = arm_q.txe;
            clr_o.txc = arm_q.txc;
        end
        if (data_rd) begin
            clr_o.rxf = arm_q.rxf;
            clr_o.idl = arm_q.idl;
            clr_o.ovr = arm_q.ovr;
            clr_o.nse = arm_q.nse;
            clr_o.frm = arm_q.frm;
            clr_o.par = arm_q.par;
        end
    end

    always_comb begin
        unique case (reg_sel)
            ADDR_STAT: reg_rdata = status_i;
            ADDR_CTLA: reg_rdata = {ien_trx_q, 4'b0000};
            ADDR_CTLB: reg_rdata = {4'b0000, ien_err_q};
            ADDR_DATA: reg_rdata = rx_data;
            default:   reg_rdata = '0;
        endcase
    end

    assign ien_trx = ien_trx_q;
    assign ien_err = ien_err_q;

    // R10
    clr_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o.rxf || clr_o.txe) |-> (data_rd || data_wr));

endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uflg_pkg::*;
#(
    parameter int IDLE_ONES_8 = 10,
    parameter int IDLE_ONES_9 = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_sel,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tx_load_stb,
    input  logic       tx_shift_done_stb,
    input  logic       tx_brk_busy,
    output logic [7:0] tx_data,
    output logic       tx_full,
    input  logic       rx_char_stb,
    input  logic [7:0] rx_char_data,
    input  logic       rx_bit_stb,
    input  logic       rx_bit_val,
    input  logic       rx_nine_bit,
    input  logic       rx_noise_stb,
    input  logic       rx_frame_stb,
    input  logic       rx_parity_stb,
    output logic       tx_irq,
    output logic       rx_irq,
    output logic       err_irq
);

    uflg_status_t status, clr;
    logic [REG_W-1:0] rx_data;
    logic [3:0] ien_trx, ien_err;
    logic data_wr, data_rd;

    uflg_tx_fsm u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .data_wr        (data_wr),
        .wdata          (reg_wdata),
        .load_stb       (tx_load_stb),
        .shift_done_stb (tx_shift_done_stb),
        .brk_busy       (tx_brk_busy),
        .clr_txe        (clr.txe),
        .clr_txc        (clr.txc),
        .txe            (status.txe),
        .txc            (status.txc),
        .tx_data        (tx_data),
        .tx_full        (tx_full)
    );

    uflg_rx_track #(
        .IDLE_ONES_8 (IDLE_ONES_8),
        .IDLE_ONES_9 (IDLE_ONES_9)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_stb   (rx_char_stb),
        .char_data  (rx_char_data),
        .bit_stb    (rx_bit_stb),
        .bit_val    (rx_bit_val),
        .nine_bit   (rx_nine_bit),
        .noise_stb  (rx_noise_stb),
        .frame_stb  (rx_frame_stb),
        .parity_stb (rx_parity_stb),
        .clr_rxf    (clr.rxf),
        .clr_idl    (clr.idl),
        .clr_ovr    (clr.ovr),
        .clr_nse    (clr.nse),
        .clr_frm    (clr.frm),
        .clr_par    (clr.par),
        .rxf        (status.rxf),
        .idl        (status.idl),
        .ovr        (status.ovr),
        .nse        (status.nse),
        .frm        (status.frm),
        .par        (status.par),
        .rx_data    (rx_data)
    );

    uflg_regif u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .status_i  (status),
        .rx_data   (rx_data),
        .reg_rdata (reg_rdata),
        .ien_trx   (ien_trx),
        .ien_err   (ien_err),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .clr_o     (clr)
    );

    assign tx_irq  = (status.txe & ien_trx[3]) | (status.txc & ien_trx[2]);
    assign rx_irq  = (status.rxf & ien_trx[1]) | (status.idl & ien_trx[0]);
    assign err_irq = |({status.ovr, status.nse, status.frm, status.par} & ien_err);

    // R10
    rxf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status.rxf) |-> $past(reg_rd && reg_sel == ADDR_DATA));

    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_noise_stb) |=> status.nse);

endmodule

// File: tb/uart_flag_ctrl_tb_top.sv
module uart_flag_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic tx_load_stb = 1'b0, tx_shift_done_stb = 1'b0, tx_brk_busy = 1'b0;
    logic [7:0] tx_data;
    logic tx_full;
    logic rx_char_stb = 1'b0;
    logic [7:0] rx_char_data = '0;
    logic rx_bit_stb = 1'b0, rx_bit_val = 1'b0, rx_nine_bit = 1'b0;
    logic rx_noise_stb = 1'b0, rx_frame_stb = 1'b0, rx_parity_stb = 1'b0;
    logic tx_irq, rx_irq, err_irq;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    uart_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_load_stb(tx_load_stb),
        .tx_shift_done_stb(tx_shift_done_stb), .tx_brk_busy(tx_brk_busy),
        .tx_data(tx_data), .tx_full(tx_full), .rx_char_stb(rx_char_stb),
        .rx_char_data(rx_char_data), .rx_bit_stb(rx_bit_stb), .rx_bit_val(rx_bit_val),
        .rx_nine_bit(rx_nine_bit), .rx_noise_stb(rx_noise_stb), .rx_frame_stb(rx_frame_stb),
        .rx_parity_stb(rx_parity_stb), .tx_irq(tx_irq), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // {ctrl B enables[3:0], noise/frame/parity events[2:0], expected err_irq}
    localparam logic [7:0] ERR_VEC [8] = '{
        {4'b0000, 3'b111, 1'b0},
        {4'b0100, 3'b100, 1'b1},
        {4'b0100, 3'b011, 1'b0},
        {4'b0010, 3'b010, 1'b1},
        {4'b0001, 3'b001, 1'b1},
        {4'b0001, 3'b110, 1'b0},
        {4'b1000, 3'b111, 1'b0},
        {4'b0111, 3'b101, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_sel = a;
        reg_rd  = 1'b1;
        #1;
        d = reg_rdata;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_sel   = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic send_char(input logic [7:0] d);
        rx_char_data = d;
        rx_char_stb  = 1'b1;
        step();
        rx_char_stb  = 1'b0;
    endtask

    task automatic send_bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            rx_bit_stb = 1'b1;
            rx_bit_val = v;
            step();
        end
        rx_bit_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        do_reset();

        // R1 reset state
        rd(2'd0, rv); check("R1 status", rv, 8'hC0);
        rd(2'd1, rv); check("R1 ctrlA", rv, 8'h00);
        rd(2'd2, rv); check("R1 ctrlB", rv, 8'h00);
        check("R1 irqs", {tx_irq, rx_irq, err_irq}, 3'b000);

        // R11 writable fields
        wr(2'd1, 8'hFF); rd(2'd1, rv); check("R11 ctrlA", rv, 8'hF0);
        wr(2'd2, 8'hFF); rd(2'd2, rv); check("R11 ctrlB", rv, 8'h0F);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // Error table: R8 flags, R9 masking
        for (int i = 0; i < 8; i++) begin
            do_reset();
            wr(2'd2, {4'b0000, ERR_VEC[i][7:4]});
            rx_noise_stb  = ERR_VEC[i][3];
            rx_frame_stb  = ERR_VEC[i][2];
            rx_parity_stb = ERR_VEC[i][1];
            step();
            rx_noise_stb = 1'b0; rx_frame_stb = 1'b0; rx_parity_stb = 1'b0;
            check("R9 err_irq", err_irq, ERR_VEC[i][0]);
            rd(2'd0, rv);
            check("R8 status", rv, {5'b11000, ERR_VEC[i][3:1]});
        end

        // Transmit path
        do_reset();
        rd(2'd0, rv);
        wr(2'd3, 8'h5A);
        check("R11 tx_data", tx_data, 8'h5A);
        check("R11 tx_full", tx_full, 1'b1);
        step(); step();
        rd(2'd0, rv); check("R10 tx clear / R3 queued", rv, 8'h00);
        tx_load_stb = 1'b1; step(); tx_load_stb = 1'b0;
        check("R2 tx_full after load", tx_full, 1'b0);
        rd(2'd0, rv); check("R2 txe set", rv, 8'h80);
        wr(2'd1, 8'h80); check("R2 tx_irq", tx_irq, 1'b1);
        wr(2'd1, 8'h40); check("R3 tx_irq txc off", tx_irq, 1'b0);
        tx_brk_busy = 1'b1;
        tx_shift_done_stb = 1'b1; step(); tx_shift_done_stb = 1'b0;
        step(); step();
        check("R3 blocked by break", tx_irq, 1'b0);
        tx_brk_busy = 1'b0;
        step();
        check("R3 txc after break", tx_irq, 1'b1);

        // Receive path
        do_reset();
        wr(2'd1, 8'h20);
        send_char(8'h33);
        check("R4 rx_irq", rx_irq, 1'b1);
        rd(2'd3, rv); check("R4 data", rv, 8'h33);
        check("R10 unarmed read keeps rxf", rx_irq, 1'b1);
        send_char(8'h44);
        check("R7 err_irq masked", err_irq, 1'b0);
        wr(2'd2, 8'h08); check("R9 ovr err_irq", err_irq, 1'b1);
        rd(2'd3, rv); check("R7 data kept", rv, 8'h33);
        rd(2'd0, rv); check("R7 status", rv, 8'hE8);
        rd(2'd3, rv);
        check("R10 rxf cleared", rx_irq, 1'b0);
        check("R10 ovr cleared", err_irq, 1'b0);

        // R12 collision
        send_char(8'h55);
        rd(2'd0, rv);
        reg_sel = 2'd3; reg_rd = 1'b1;
        rx_char_data = 8'h66; rx_char_stb = 1'b1;
        step();
        reg_rd = 1'b0; rx_char_stb = 1'b0;
        check("R12 rxf kept", rx_irq, 1'b1);
        rd(2'd0, rv); check("R12 no overrun", rv, 8'hE0);
        rd(2'd3, rv); check("R12 new data", rv, 8'h66);

        // Idle detection
        do_reset();
        wr(2'd1, 8'h10);
        rx_nine_bit = 1'b0;
        send_bits(9, 1'b1); check("R5 below 10", rx_irq, 1'b0);
        send_bits(1, 1'b0); send_bits(9, 1'b1);
        check("R5 zero restarts", rx_irq, 1'b0);
        send_bits(1, 1'b1); check("R5 tenth one", rx_irq, 1'b1);
        rd(2'd0, rv); check("R5 status", rv, 8'hD0);
        rd(2'd3, rv); check("R10 idle cleared", rx_irq, 1'b0);
        send_bits(25, 1'b1); check("R6 locked", rx_irq, 1'b0);
        rd(2'd0, rv); check("R6 status", rv, 8'hC0);
        send_char(8'h11);
        rx_nine_bit = 1'b1;
        send_bits(10, 1'b1); check("R5 nine-bit below 11", rx_irq, 1'b0);
        send_bits(1, 1'b1); check("R5 nine-bit eleventh", rx_irq, 1'b1);

        finish_run();
    end

endmodule